// File: doc/BRIEF.md
# Asynchronous External Memory Access Sequencer

This block carries out a single read or write to an external asynchronous static RAM or NOR-type memory. A host offers a request with a valid flag, a write flag, an address and write data, and holds it until the block answers with a one-cycle ready pulse. The block then splits the access into phases whose lengths are counted in system clock cycles. It drives the memory's active-low select, read strobe, write strobe and address-latch strobe. It also drives the address bus and a split data bus made of an output value, an output enable and an input value.

Two bus arrangements are supported. In the plain arrangement the address has its own bus. In the shared arrangement the low address bits travel first on the data lines, and a latch strobe marks them as an address. The phase lengths come from configuration inputs. These inputs are captured together with the request when it is accepted, so a running access and its recovery gap are never disturbed by a change.

Top module: `amseq_top`

## Requirements
- R1: After reset and whenever no access is running, `mem_ce_n`, `mem_oe_n`, `mem_we_n` and `mem_adv_n` are high, and `mem_dq_oe` and `req_ready` are low.
- R2: A request that is accepted while the block is idle selects the memory (`mem_ce_n` low) from the next cycle onward. The first phase is an address setup of `cfg_setup` cycles (0 to 15), and a value of 0 skips that phase.
- R3: With `cfg_mux` = 1, `mem_adv_n` is low for exactly the address-setup cycles. An address-hold phase of `cfg_hold` cycles follows, with 0 treated as 1. Through both address phases `mem_dq_oe` is 1 and `mem_dq_out` carries `req_addr[DW-1:0]`.
- R4: With `cfg_mux` = 0, there is no hold phase, `mem_adv_n` stays high, and `mem_dq_oe` stays low during address setup.
- R5: The data phase lasts `cfg_dset`+1 cycles, where `cfg_dset` is 8 bits wide, so the phase runs from 1 to 256 cycles.
- R6: A read holds `mem_oe_n` low for the whole data phase. `req_ready` is high only in its last cycle, and in that cycle `rsp_rdata` equals `mem_dq_in`.
- R7: A write holds `mem_we_n` low and drives `mem_dq_out` with the write data (`mem_dq_oe` = 1) for the whole data phase, with `mem_oe_n` high.
- R8: After the data phase ends, the memory stays deselected for `cfg_turn` cycles (0 to 15) of recovery, plus one idle cycle in which the next request is accepted.
- R9: The request and the configuration are captured when the request is accepted. Changes to them later in the access alter neither that access nor its recovery gap, and `mem_addr` stays steady while the memory is selected.
- R10: The read and write strobes are never low together, and none of the strobes is low while the memory is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_mux | input | 1 | 1 selects the shared address/data arrangement |
| cfg_setup | input | 4 | Address setup length in cycles |
| cfg_hold | input | 4 | Address hold length in cycles (shared arrangement only, 0 acts as 1) |
| cfg_dset | input | 8 | Data phase length minus one |
| cfg_turn | input | 4 | Recovery length in cycles after an access |
| req_valid | input | 1 | Host request present, held until `req_ready` |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | One-cycle completion pulse in the last data cycle |
| rsp_rdata | output | DW | Read data, valid while `req_ready` is high on a read |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_adv_n | output | 1 | Address latch strobe, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_addr | output | AW | Address bus |
| mem_dq_out | output | DW | Value driven onto the data lines |
| mem_dq_oe | output | 1 | 1 when the block drives the data lines |
| mem_dq_in | input | DW | Value read from the data lines |

## Verification
The bench targets the zero-length edges: a setup of 0 in both arrangements, a hold of 0 that must still give one cycle, and a data value of 0 that must give one cycle. A design that got these wrong would drop a phase, drive the latch strobe with no setup, or wait 256 cycles. It also runs a 256-cycle data phase and back-to-back requests with recoveries of 0 and 15. A counter that was off by one there would shorten the gap or merge two accesses. While an access runs, the bench scrambles the configuration and the request inputs, so a design that read them live would change its phase lengths, address or data mid-access. The memory-side read value is correct only in the last data cycle, so a design that returned data from an earlier cycle would report wrong read data.

// File: rtl/amseq_pkg.sv
package amseq_pkg;

  parameter int SETUP_W = 4;
  parameter int HOLD_W  = 4;
  parameter int DSET_W  = 8;
  parameter int TURN_W  = 4;

  localparam int SH_MAX = (SETUP_W > HOLD_W) ? SETUP_W : HOLD_W;
  localparam int DT_MAX = (DSET_W > TURN_W) ? DSET_W : TURN_W;
  localparam int CNT_W  = (SH_MAX > DT_MAX) ? SH_MAX : DT_MAX;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_HOLD  = 3'd2,
    PH_DATA  = 3'd3,
    PH_TURN  = 3'd4
  } phase_e;

  typedef struct packed {
    logic              mux;
    logic [SETUP_W-1:0] setup;
    logic [HOLD_W-1:0]  hold;
    logic [DSET_W-1:0]  dset;
    logic [TURN_W-1:0]  turn;
  } timing_t;

  // hold of zero is promoted to one cycle; returns length minus one
  function automatic logic [CNT_W-1:0] hold_last(input logic [HOLD_W-1:0] h);
    logic [CNT_W-1:0] r;
    if (h == '0) r = '0;
    else         r = CNT_W'(h) - CNT_W'(1);
    return r;
  endfunction

endpackage

// File: rtl/amseq_rst_sync.sv
module amseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/amseq_req_latch.sv
module amseq_req_latch
  import amseq_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture_en,
  input  timing_t       cfg_in,
  input  logic          write_in,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  output timing_t       cfg_q,
  output logic          write_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q
);

  timing_t       cfg_d;
  logic          write_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] wdata_d;

  always_comb begin
    cfg_d   = cfg_q;
    write_d = write_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (capture_en) begin
      cfg_d   = cfg_in;
      write_d = write_in;
      addr_d  = addr_in;
      wdata_d = wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      cfg_q   <= cfg_d;
      write_q <= write_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

endmodule

// File: rtl/amseq_phase_seq.sv
module amseq_phase_seq
  import amseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  timing_t cfg_in,
  input  timing_t cfg_q,
  output phase_e  phase,
  output logic    phase_last,
  output logic    accept
);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero   = (cnt_q == '0);
  assign accept     = (phase_q == PH_IDLE) && req_valid;
  assign phase      = phase_q;
  assign phase_last = cnt_zero;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          if (cfg_in.setup != '0) begin
            phase_d = PH_SETUP;
            cnt_d   = CNT_W'(cfg_in.setup) - CNT_W'(1);
          end else if (cfg_in.mux) begin
            phase_d = PH_HOLD;
            cnt_d   = hold_last(cfg_in.hold);
          end else begin
            phase_d = PH_DATA;
            cnt_d   = CNT_W'(cfg_in.dset);
          end
        end
      end
      PH_SETUP: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (cfg_q.mux) begin
          phase_d = PH_HOLD;
          cnt_d   = hold_last(cfg_q.hold);
        end else begin
          phase_d = PH_DATA;
          cnt_d   = CNT_W'(cfg_q.dset);
        end
      end
      PH_HOLD: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else begin
          phase_d = PH_DATA;
          cnt_d   = CNT_W'(cfg_q.dset);
        end
      end
      PH_DATA: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (cfg_q.turn != '0) begin
          phase_d = PH_TURN;
          cnt_d   = CNT_W'(cfg_q.turn) - CNT_W'(1);
        end else begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      end
      PH_TURN: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/amseq_pin_drive.sv
module amseq_pin_drive
  import amseq_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  phase_e        phase,
  input  logic          phase_last,
  input  logic          mux,
  input  logic          write,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] dq_in,
  output logic          ce_n,
  output logic          adv_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          dq_oe,
  output logic [DW-1:0] dq_out,
  output logic          done,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] addr_on_dq;
  logic          in_addr, in_data;

  generate
    if (AW >= DW) begin : g_addr_slice
      assign addr_on_dq = addr[DW-1:0];
    end else begin : g_addr_pad
      assign addr_on_dq = {{(DW-AW){1'b0}}, addr};
    end
  endgenerate

  always_comb begin
    in_addr = (phase == PH_SETUP) || (phase == PH_HOLD);
    in_data = (phase == PH_DATA);
    ce_n    = !(in_addr || in_data);
    adv_n   = !(mux && (phase == PH_SETUP));
    oe_n    = !(in_data && !write);
    we_n    = !(in_data && write);
    dq_oe   = (mux && in_addr) || (in_data && write);
    dq_out  = in_data ? wdata : (mux ? addr_on_dq : '0);
    done    = in_data && phase_last;
    rdata   = (done && !write) ? dq_in : '0;
  end

endmodule

// File: rtl/amseq_top.sv
module amseq_top
  import amseq_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_mux,
  input  logic [SETUP_W-1:0] cfg_setup,
  input  logic [HOLD_W-1:0]  cfg_hold,
  input  logic [DSET_W-1:0]  cfg_dset,
  input  logic [TURN_W-1:0]  cfg_turn,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [AW-1:0]      req_addr,
  input  logic [DW-1:0]      req_wdata,
  output logic               req_ready,
  output logic [DW-1:0]      rsp_rdata,
  output logic               mem_ce_n,
  output logic               mem_adv_n,
  output logic               mem_oe_n,
  output logic               mem_we_n,
  output logic [AW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_dq_out,
  output logic               mem_dq_oe,
  input  logic [DW-1:0]      mem_dq_in
);

  logic          rst_n_sync;
  logic          accept;
  timing_t       cfg_in, cfg_q;
  logic          write_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  phase_e        phase;
  logic          phase_last;

  always_comb begin
    cfg_in.mux   = cfg_mux;
    cfg_in.setup = cfg_setup;
    cfg_in.hold  = cfg_hold;
    cfg_in.dset  = cfg_dset;
    cfg_in.turn  = cfg_turn;
  end

  amseq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  amseq_req_latch #(.AW(AW), .DW(DW)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .capture_en (accept),
    .cfg_in     (cfg_in),
    .write_in   (req_write),
    .addr_in    (req_addr),
    .wdata_in   (req_wdata),
    .cfg_q      (cfg_q),
    .write_q    (write_q),
    .addr_q     (addr_q),
    .wdata_q    (wdata_q)
  );

  amseq_phase_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .req_valid  (req_valid),
    .cfg_in     (cfg_in),
    .cfg_q      (cfg_q),
    .phase      (phase),
    .phase_last (phase_last),
    .accept     (accept)
  );

  amseq_pin_drive #(.AW(AW), .DW(DW)) u_pins (
    .phase      (phase),
    .phase_last (phase_last),
    .mux        (cfg_q.mux),
    .write      (write_q),
    .addr       (addr_q),
    .wdata      (wdata_q),
    .dq_in      (mem_dq_in),
    .ce_n       (mem_ce_n),
    .adv_n      (mem_adv_n),
    .oe_n       (mem_oe_n),
    .we_n       (mem_we_n),
    .dq_oe      (mem_dq_oe),
    .dq_out     (mem_dq_out),
    .done       (req_ready),
    .rdata      (rsp_rdata)
  );

  assign mem_addr = addr_q;

endmodule

// File: rtl/amseq_checker.sv
module amseq_checker #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          mem_ce_n,
  input logic          mem_adv_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe,
  input logic [AW-1:0] mem_addr
);

  p_quiet_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_oe_n && mem_we_n && mem_adv_n && !req_ready));

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  p_ready_in_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_oe_n || !mem_we_n));

  p_we_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !req_ready) |=> !mem_we_n);

  p_we_drives_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);

  p_adv_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_adv_n) |-> $fell(mem_ce_n));

  p_addr_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  p_gap_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> mem_ce_n);

endmodule

bind amseq_top amseq_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .mem_ce_n  (mem_ce_n),
  .mem_adv_n (mem_adv_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe),
  .mem_addr  (mem_addr)
);

// File: tb/tb_amseq_top.sv
module tb_amseq_top;
  localparam int AW = 24;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_mux;
  logic [3:0]    cfg_setup, cfg_hold, cfg_turn;
  logic [7:0]    cfg_dset;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ready;
  logic [DW-1:0] rsp_rdata;
  logic          mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out, mem_dq_in;

  int n_cmp = 0;
  int n_bad = 0;
  int prev_turn = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  amseq_top #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_mux(cfg_mux), .cfg_setup(cfg_setup),
    .cfg_hold(cfg_hold), .cfg_dset(cfg_dset), .cfg_turn(cfg_turn),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return a[DW-1:0] ^ a[AW-1:AW-DW] ^ 16'hA5C3;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_quiet(input string req);
    chk(req, "ce_n", 32'(mem_ce_n), 1);
    chk(req, "oe_n", 32'(mem_oe_n), 1);
    chk(req, "we_n", 32'(mem_we_n), 1);
    chk(req, "adv_n", 32'(mem_adv_n), 1);
    chk(req, "dq_oe", 32'(mem_dq_oe), 0);
    chk(req, "ready", 32'(req_ready), 0);
  endtask

  // Starts at a negedge; returns at the negedge of the ready cycle.
  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic mx, input int su, input int ho, input int ds,
                        input int tu, input bit b2b);
    int a_len, h_len, total, gap, exp_gap;
    bit done_gap;
    cfg_mux = mx; cfg_setup = 4'(su); cfg_hold = 4'(ho);
    cfg_dset = 8'(ds); cfg_turn = 4'(tu);
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    a_len = su;
    h_len = mx ? ((ho == 0) ? 1 : ho) : 0;
    total = a_len + h_len + ds + 1;
    exp_gap = b2b ? prev_turn + 1 : 0;
    gap = 0;
    done_gap = 0;
    while (!done_gap) begin
      @(posedge clk); @(negedge clk);
      if (mem_ce_n) gap++;
      else done_gap = 1;
      if (gap > 40) done_gap = 1;
    end
    chk("R8", "deselect gap", 32'(gap), 32'(exp_gap));
    for (int k = 0; k < total; k++) begin
      bit in_a, exp_oe;
      if (k > 0) begin @(posedge clk); @(negedge clk); end
      mem_dq_in = (k == total - 1) ? mem_word(a) : ~mem_word(a);
      #1;
      in_a = (k < a_len + h_len);
      exp_oe = (mx && in_a) || (!in_a && wr);
      chk("R2", "ce_n", 32'(mem_ce_n), 0);
      chk(mx ? "R3" : "R4", "adv_n", 32'(mem_adv_n), (mx && k < a_len) ? 0 : 1);
      chk(mx ? "R3" : "R4", "dq_oe", 32'(mem_dq_oe), 32'(exp_oe));
      if (exp_oe && in_a) chk("R3", "dq addr", 32'(mem_dq_out), 32'(a[DW-1:0]));
      if (exp_oe && !in_a) chk("R7", "dq wdata", 32'(mem_dq_out), 32'(d));
      chk("R6", "oe_n", 32'(mem_oe_n), (!in_a && !wr) ? 0 : 1);
      chk("R7", "we_n", 32'(mem_we_n), (!in_a && wr) ? 0 : 1);
      chk("R9", "mem_addr", 32'(mem_addr), 32'(a));
      chk("R5", "ready timing", 32'(req_ready), (k == total - 1) ? 1 : 0);
      if (k == total - 1 && !wr) chk("R6", "read data", 32'(rsp_rdata), 32'(mem_word(a)));
      if (k == 0) begin
        cfg_mux = ~mx; cfg_setup = 4'($urandom); cfg_hold = 4'($urandom);
        cfg_dset = 8'($urandom); cfg_turn = 4'($urandom);
        req_addr = AW'($urandom); req_wdata = DW'($urandom); req_write = ~wr;
      end
    end
    req_valid = 1'b0;
    prev_turn = tu;
  endtask

  task automatic go_idle();
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      chk_quiet("R1");
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    cfg_mux = 0; cfg_setup = 0; cfg_hold = 0; cfg_dset = 0; cfg_turn = 0;
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; mem_dq_in = '0;
    repeat (3) @(negedge clk);
    chk_quiet("R1");
    rst_n = 1'b1;
    go_idle();
    // directed corners
    access(1'b0, 24'h12_3456, 16'h0000, 1'b1, 0, 0, 0, 0, 1'b0);
    access(1'b1, 24'hAB_CDEF, 16'h5A5A, 1'b0, 0, 3, 0, 15, 1'b1);
    access(1'b0, 24'h00_0F0F, 16'h0000, 1'b1, 15, 15, 255, 0, 1'b1);
    access(1'b1, 24'hFF_FFFF, 16'hFFFF, 1'b0, 1, 0, 255, 1, 1'b1);
    go_idle();
    access(1'b1, 24'h55_AA55, 16'h1234, 1'b1, 2, 1, 3, 7, 1'b0);
    access(1'b0, 24'h33_2211, 16'h0000, 1'b0, 4, 9, 1, 0, 1'b1);
    // constrained random
    for (int i = 0; i < 60; i++) begin
      bit b2b;
      int ds;
      b2b = ($urandom % 2) == 1;
      if (!b2b) go_idle();
      ds = (i % 15 == 7) ? 255 : int'($urandom % 12);
      access(1'($urandom), AW'($urandom), DW'($urandom), 1'($urandom),
             int'($urandom % 16), int'($urandom % 16), ds, int'($urandom % 16), b2b);
    end
    go_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule